// File: doc/BRIEF.md
# System Configuration and Halt Control Register

This block is a 32-bit configuration register that sits between a processor board and its backplane. It follows the backplane power-good line and shows it to software. It holds an enable bit that decides whether the backplane halt line may stop the CPU. It also holds a mode bit that picks what happens when the backplane dc-ok line drops. Software reaches the register through a simple write port with four byte enables, so a longword, a word or a single byte can be written. The read data is always present on the read port.

A dc-ok negation is seen as a falling edge after a synchroniser. A small state machine then takes one of two paths:

- **Board reset path (mode bit clear).** The machine goes from `S_IDLE` to `S_RESET_HOLD` on transition `T_IDLE_TO_RESET`. It holds the system reset output for a fixed number of cycles, then goes back to `S_IDLE` on `T_RESET_DONE`. It reports halt code 3.
- **Halt request path (mode bit set).** The machine goes from `S_IDLE` to `S_HALT_ISSUE` on `T_IDLE_TO_HALT`. It raises the CPU halt request for one cycle, then returns to `S_IDLE` on `T_HALT_DONE`. It reports halt code 2.

When a negation arrives while the CPU reports itself halted, the programmable bits are cleared.

Top module: `syscfg_halt_ctl`

## Requirements
- R1: After power-up reset the read data is zero, and system reset, halt request, halt code, code strobe and the halt status flag are all low.
- R2: Bit 14 (halt enable) is written only when byte enable 1 is set. Bit 7 (dc-ok mode) is written only when byte enable 0 is set. Byte, word and longword writes therefore each update exactly the lanes they enable.
- R3: Read bit 15 follows the power-good input two clock edges after the input changes. Writes to bit 15 have no effect.
- R4: Every read bit other than 15, 14 and 7 is zero, whatever has been written.
- R5: With halt enable set, the backplane halt input raises the halt request two edges after it asserts. It also sets the sticky halt status flag one edge later.
- R6: With halt enable clear, the backplane halt input has no effect on the halt request or on the halt status flag.
- R7: With mode 0, a dc-ok negation raises system reset for exactly 16 cycles. The halt code output becomes 3, with a one-cycle strobe on the edge where the reset rises.
- R8: With mode 1, a dc-ok negation raises the halt request for exactly one cycle, sets the halt code output to 2 with a one-cycle strobe, and does not assert system reset.
- R9: A dc-ok line held low triggers only one action and one strobe per negation.
- R10: A dc-ok negation while the CPU-halted input is high clears bits 14 and 7. A negation while it is low leaves them unchanged.
- R11: If a register write lands in the same cycle as a clear caused by a negation, the clear wins. The action taken follows the mode value held before that edge.
- R12: The halt status flag is cleared while system reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| reg_wr | input | 1 | Register write strobe |
| reg_be | input | 4 | Byte enables for the write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| ext_halt_in | input | 1 | Backplane halt line, active high |
| pwr_ok_in | input | 1 | Backplane power-good line |
| dc_ok_in | input | 1 | Backplane dc-ok line, negation is a falling edge |
| cpu_halted | input | 1 | CPU is in the halted state |
| halt_req | output | 1 | Halt request to the CPU |
| sys_reset | output | 1 | Board reset, active high |
| halt_code | output | 2 | Code of the last dc-ok action |
| halt_code_vld | output | 1 | One-cycle strobe with a new halt code |
| halt_err_flag | output | 1 | Sticky flag: the backplane halt line stopped the CPU |

## Verification
A dc-ok negation seen while the CPU is halted clears the mode and enable bits on the same edge where the state machine reads the mode bit. A software write can also fall on that edge. The bench provokes this by timing a longword write that sets both bits so that it reaches the edge where the synchronised falling edge is acted on.

The check on the next cycle expects three things:
- both bits read back as zero;
- the strobe carries code 2, because the old mode was 1;
- the halt request pulses.

A design that lets the write win, or that uses the cleared mode, fails this check.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
    localparam int REG_W    = 32;
    localparam int POK_BIT  = 15;
    localparam int HEN_BIT  = 14;
    localparam int MODE_BIT = 7;
    localparam int HEN_LANE  = HEN_BIT / 8;
    localparam int MODE_LANE = MODE_BIT / 8;
    localparam logic [1:0] HCODE_RESET  = 2'd3;
    localparam logic [1:0] HCODE_HALTIN = 2'd2;

    typedef enum logic [1:0] {
        S_IDLE       = 2'd0,
        S_RESET_HOLD = 2'd1,
        S_HALT_ISSUE = 2'd2
    } dck_state_e;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/scfg_regs.sv
module scfg_regs
    import scfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [3:0]       be,
    input  logic [REG_W-1:0] wdata,
    input  logic             clr,
    input  logic             pok,
    output logic             halt_en,
    output logic             mode,
    output logic [REG_W-1:0] rdata
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_en <= 1'b0;
            mode    <= 1'b0;
        end else if (clr) begin
            halt_en <= 1'b0;
            mode    <= 1'b0;
        end else if (wr) begin
            if (be[HEN_LANE])  halt_en <= wdata[HEN_BIT];
            if (be[MODE_LANE]) mode    <= wdata[MODE_BIT];
        end
    end

    always_comb begin
        rdata           = '0;
        rdata[POK_BIT]  = pok;
        rdata[HEN_BIT]  = halt_en;
        rdata[MODE_BIT] = mode;
    end

    a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!halt_en && !mode));
    a_r2_lane_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !(wr && be[HEN_LANE])) |=> $stable(halt_en));
endmodule

// File: rtl/scfg_dcok_fsm.sv
module scfg_dcok_fsm
    import scfg_pkg::*;
#(
    parameter int RST_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dcok_fall,
    input  logic       mode,
    output logic       sys_reset,
    output logic       halt_pulse,
    output logic [1:0] hcode,
    output logic       hcode_vld
);
    localparam int CW = (RST_CYCLES > 1) ? $clog2(RST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(RST_CYCLES - 1);

    dck_state_e state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= (state == S_RESET_HOLD) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:       if (dcok_fall) nxt = mode ? S_HALT_ISSUE : S_RESET_HOLD;
            S_RESET_HOLD: if (cnt == LAST) nxt = S_IDLE;
            S_HALT_ISSUE: nxt = S_IDLE;
            default:      nxt = S_IDLE;
        endcase
    end

    always_comb begin
        sys_reset  = (state == S_RESET_HOLD);
        halt_pulse = (state == S_HALT_ISSUE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcode     <= 2'd0;
            hcode_vld <= 1'b0;
        end else if (state == S_IDLE && dcok_fall) begin
            hcode     <= mode ? HCODE_HALTIN : HCODE_RESET;
            hcode_vld <= 1'b1;
        end else begin
            hcode_vld <= 1'b0;
        end
    end

    a_r7_reset_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset) |-> (hcode_vld && hcode == HCODE_RESET));
    a_r8_halt_single: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse |=> !halt_pulse);
    a_r8_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        halt_pulse |-> !sys_reset);
    a_r9_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        hcode_vld |=> !hcode_vld);
    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        !sys_reset |-> (cnt == '0));
endmodule

// File: rtl/syscfg_halt_ctl.sv
module syscfg_halt_ctl
    import scfg_pkg::*;
#(
    parameter int RST_CYCLES  = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [3:0]  reg_be,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        ext_halt_in,
    input  logic        pwr_ok_in,
    input  logic        dc_ok_in,
    input  logic        cpu_halted,
    output logic        halt_req,
    output logic        sys_reset,
    output logic [1:0]  halt_code,
    output logic        halt_code_vld,
    output logic        halt_err_flag
);
    logic [2:0] sync_q;
    logic ehalt_s, dcok_s, pok_s, dcok_d, dcok_fall, clr;
    logic halt_en, mode, halt_pulse;

    scfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({ext_halt_in, dc_ok_in, pwr_ok_in}),
        .q(sync_q)
    );
    assign {ehalt_s, dcok_s, pok_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dcok_d <= 1'b0;
        else        dcok_d <= dcok_s;
    end
    assign dcok_fall = dcok_d & ~dcok_s;
    assign clr       = dcok_fall & cpu_halted;

    scfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .be(reg_be), .wdata(reg_wdata),
        .clr(clr), .pok(pok_s), .halt_en(halt_en), .mode(mode), .rdata(reg_rdata)
    );

    scfg_dcok_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .dcok_fall(dcok_fall), .mode(mode),
        .sys_reset(sys_reset), .halt_pulse(halt_pulse),
        .hcode(halt_code), .hcode_vld(halt_code_vld)
    );

    assign halt_req = halt_pulse | (halt_en & ehalt_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  halt_err_flag <= 1'b0;
        else if (sys_reset)          halt_err_flag <= 1'b0;
        else if (halt_en && ehalt_s) halt_err_flag <= 1'b1;
    end

    a_r12_flag_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |=> !halt_err_flag);
    a_r5_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_err_flag) |-> $past(halt_req));
endmodule

// File: tb/sim_syscfg_halt_ctl.sv
module sim_syscfg_halt_ctl;
    logic clk = 0, rst_n = 0;
    logic reg_wr = 0;
    logic [3:0] reg_be = 0;
    logic [31:0] reg_wdata = 0, reg_rdata;
    logic ext_halt_in = 0, pwr_ok_in = 0, dc_ok_in = 1, cpu_halted = 0;
    logic halt_req, sys_reset, halt_code_vld, halt_err_flag;
    logic [1:0] halt_code;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    syscfg_halt_ctl u0 (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] be, logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_be = be; reg_wdata = d;
        @(negedge clk); reg_wr = 0; reg_be = 0;
    endtask

    task automatic dc_restore();
        @(negedge clk); dc_ok_in = 1;
        repeat (4) @(negedge clk);
    endtask

    // drop dc-ok and count outputs over a window
    task automatic dc_drop(int win, output int n_rst, output int n_halt,
                           output int n_vld, output logic [1:0] code);
        n_rst = 0; n_halt = 0; n_vld = 0; code = 0;
        @(negedge clk); dc_ok_in = 0;
        for (int i = 0; i < win; i++) begin
            @(negedge clk);
            n_rst += int'(sys_reset); n_halt += int'(halt_req); n_vld += int'(halt_code_vld);
            if (halt_code_vld) code = halt_code;
        end
    endtask

    task automatic t_reset();
        chk("R1 rdata", reg_rdata, 0);
        chk("R1 outs", {sys_reset, halt_req, halt_code, halt_code_vld, halt_err_flag}, 0);
    endtask

    task automatic t_lanes();
        wr(4'b0001, 32'hFFFF_FFFF);
        chk("R2 byte0", reg_rdata, 32'h0000_0080);
        wr(4'b0010, 32'hFFFF_FFFF);
        chk("R2 byte1", reg_rdata, 32'h0000_4080);
        wr(4'b0011, 32'h0000_0000);
        chk("R2 word", reg_rdata, 0);
        wr(4'b1111, 32'hFFFF_FFFF);
        chk("R4 unused zero", reg_rdata & ~32'h0000_C080, 0);
        chk("R3 ro bit15", reg_rdata[15], 0);
        wr(4'b1111, 32'h0);
        chk("R2 longword", reg_rdata, 0);
    endtask

    task automatic t_pok();
        @(negedge clk); pwr_ok_in = 1;
        @(negedge clk); chk("R3 pok lag", reg_rdata[15], 0);
        @(negedge clk); chk("R3 pok set", reg_rdata[15], 1);
        pwr_ok_in = 0;
        repeat (2) @(negedge clk);
        chk("R3 pok clr", reg_rdata[15], 0);
    endtask

    task automatic t_halt_off();
        int hits = 0;
        @(negedge clk); ext_halt_in = 1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); hits += int'(halt_req | halt_err_flag);
        end
        chk("R6 ignored", hits, 0);
        ext_halt_in = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_halt_on();
        wr(4'b0011, 32'h0000_4000);
        @(negedge clk); ext_halt_in = 1;
        @(negedge clk); chk("R5 lag", halt_req, 0);
        @(negedge clk); chk("R5 req", halt_req, 1);
        @(negedge clk); chk("R5 flag", halt_err_flag, 1);
        ext_halt_in = 0;
        repeat (3) @(negedge clk);
        chk("R5 req drop", halt_req, 0);
        chk("R5 flag sticky", halt_err_flag, 1);
    endtask

    task automatic t_mode0();
        int a, b, c; logic [1:0] cd;
        wr(4'b0001, 32'h0);
        dc_drop(40, a, b, c, cd);
        chk("R7 reset len", a, 16);
        chk("R7 code", cd, 3);
        chk("R9 one strobe", c, 1);
        chk("R12 flag clr", halt_err_flag, 0);
        dc_restore();
    endtask

    task automatic t_mode1_running();
        int a, b, c; logic [1:0] cd;
        wr(4'b0011, 32'h0000_0080);
        cpu_halted = 0;
        dc_drop(12, a, b, c, cd);
        chk("R8 no reset", a, 0);
        chk("R8 halt pulse", b, 1);
        chk("R8 code", {30'd0, cd}, 2);
        chk("R10 kept", reg_rdata & 32'h4080, 32'h80);
        dc_restore();
    endtask

    task automatic t_halted_clear();
        wr(4'b0011, 32'h0000_4080);
        cpu_halted = 1;
        @(negedge clk); dc_ok_in = 0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); reg_wr = 1; reg_be = 4'hF; reg_wdata = 32'h0000_4080;
        @(negedge clk); reg_wr = 0; reg_be = 0;
        chk("R11 clear wins", reg_rdata & 32'h4080, 0);
        chk("R10 cleared", reg_rdata, 0);
        chk("R11 old mode code", {halt_code_vld, halt_code}, 3'b110);
        chk("R11 halt pulse", halt_req, 1);
        cpu_halted = 0;
        dc_restore();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
        t_reset();
        t_lanes();
        t_pok();
        t_halt_off();
        t_halt_on();
        t_mode0();
        t_mode1_running();
        t_halted_clear();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule